// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block produces the six gate enables of an isolated full-bridge DC-DC stage that is controlled by phase shift. Four primary switches sit in two legs. The leading leg has a high switch A and a low switch B. The lagging leg has a high switch C and a low switch D. A center-tapped secondary carries two synchronous rectifier switches. Each leg toggles at a fixed half-period duty. The lagging leg trails the leading leg by a commanded number of clock counts. That offset, and not a pulse width, sets how long each half-cycle pushes energy across the transformer.

Diagonal A with D is one power-transfer pair, and diagonal B with C is the other. When the two legs agree (A with C, or B with D), the bridge freewheels with zero primary voltage. Each rectifier switch is turned off only while the diagonal that would reverse-bias it is transferring. It therefore stays on through every freewheel interval.

Every turn-on waits a programmable number of clocks after its partner's turn-off. The phase and dead-time commands are sampled only at the period boundary. Dropping the enable or raising the fault input clears all gates at the next clock edge. A one-cycle strobe marks the start of every switching period.

Top module: `pshift_bridge_gen`

## Requirements
- R1: While reset is high, enable is low or fault is high, all six gates and the strobe are low. Dropping enable or raising fault drives them all low at the next clock edge.
- R2: When running, `cycle_start` is a single-cycle pulse that repeats every PERIOD clocks (1538 by default). After enable rises, or fault falls with enable high, the first pulse appears on the second clock edge.
- R3: Let S be a strobe cycle, H = PERIOD/2 (769) and d the latched dead time. `lead_lo` is low from S, `lead_hi` is high from S+d to S+H-1, and `lead_lo` is high again from S+H+d up to the next strobe. Both are never high together.
- R4: With latched shift p, `lag_lo` drops at S+p, `lag_hi` is high from S+p+d to S+p+H-1, and `lag_lo` rises again at S+p+H+d, modulo the period. Both are never high together.
- R5: `phase_cmd` is a two's-complement word. A negative value is taken as 0, and a value above H is taken as H.
- R6: A new shift and dead time take effect only from the period that begins after the strobe following the change. While the block is idle, the latches follow the inputs.
- R7: For p > 0, `rect_bc` is low from S to S+p+d-1 and `rect_ad` is low from S+H to S+H+p+d-1, modulo the period. Both are high at all other cycles. For p = 0, both stay high in steady operation.
- R8: The dead time is counted in clocks, and a value of 0 swaps a leg's two gates in the same cycle.
- R9: `rect_bc` is never high while `lead_hi` and `lag_lo` are both high, and `rect_ad` is never high while `lead_lo` and `lag_hi` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| fault | input | 1 | Shutdown request, overrides enable |
| phase_cmd | input | PH_W (12) | Signed lag of the second leg, in clock counts (H means 180 degrees) |
| dead_cmd | input | DT_W (6) | Turn-on delay in clocks |
| lead_hi | output | 1 | Leading-leg high switch (A) |
| lead_lo | output | 1 | Leading-leg low switch (B) |
| lag_hi | output | 1 | Lagging-leg high switch (C) |
| lag_lo | output | 1 | Lagging-leg low switch (D) |
| rect_bc | output | 1 | Rectifier switch that conducts with diagonal B-C |
| rect_ad | output | 1 | Rectifier switch that conducts with diagonal A-D |
| cycle_start | output | 1 | One-clock period-start strobe |

## Verification
The assertions watch four properties on every cycle:
- each leg's two gates are never on together;
- the force-off follows enable and fault within one edge;
- strobes are exactly one period apart;
- each rectifier switch is off whenever its opposing diagonal is conducting.

The exact offsets of every edge within a period need the bench's directed scenarios, which compare each gate over whole periods against offsets computed from the shift and dead time. These cover the dead-time lengths, the clamping of out-of-range shifts, the all-on rectifier case at zero shift, and the boundary-only sampling of new commands.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int NUM_GATES  = 6;

    localparam int GI_LEAD_HI = 0;
    localparam int GI_LEAD_LO = 1;
    localparam int GI_LAG_HI  = 2;
    localparam int GI_LAG_LO  = 3;
    localparam int GI_RECT_BC = 4;
    localparam int GI_RECT_AD = 5;

    typedef logic [NUM_GATES-1:0] gate_vec_t;

    // Ideal polarity of each leg: 1 means the high switch should conduct.
    typedef struct packed {
        logic lead;
        logic lag;
    } bridge_pol_t;

    // Gates requested by the two leg polarities, before any dead time.
    function automatic gate_vec_t gate_wants(input bridge_pol_t pol);
        gate_vec_t w;
        w[GI_LEAD_HI] = pol.lead;
        w[GI_LEAD_LO] = !pol.lead;
        w[GI_LAG_HI]  = pol.lag;
        w[GI_LAG_LO]  = !pol.lag;
        // A rectifier releases only while the diagonal that blocks it transfers.
        w[GI_RECT_BC] = !(pol.lead && !pol.lag);
        w[GI_RECT_AD] = !(!pol.lead && pol.lag);
        return w;
    endfunction

endpackage

// File: rtl/pfb_gate_timer.sv
module pfb_gate_timer #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            live,
    input  logic            want,
    input  logic [DT_W-1:0] dead,
    output logic            on
);

    logic            cur;
    logic [DT_W-1:0] tmr;

    // Turn-off follows the request at once; turn-on waits 'dead' clocks.
    always_ff @(posedge clk) begin
        if (rst || !live) begin
            cur <= 1'b0;
            tmr <= '0;
        end else if (want != cur) begin
            cur <= want;
            tmr <= want ? dead : '0;
        end else if (tmr != '0) begin
            tmr <= tmr - DT_W'(1);
        end
    end

    assign on = cur && (tmr == '0);

endmodule

// File: rtl/pfb_carrier.sv
module pfb_carrier #(
    parameter int PERIOD = 1538,
    parameter int PH_W   = 12,
    parameter int DT_W   = 6,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   live,
    input  logic signed [PH_W-1:0] phase_cmd,
    input  logic [DT_W-1:0]        dead_cmd,
    output logic [CNT_W-1:0]       cnt,
    output logic [CNT_W-1:0]       shift,
    output logic [DT_W-1:0]        dead,
    output logic                   strobe
);

    localparam int                     HALF   = PERIOD / 2;
    localparam logic [CNT_W-1:0]       LAST   = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0]       HALF_C = CNT_W'(HALF);
    localparam logic signed [PH_W-1:0] HALF_S = PH_W'(HALF);

    logic [CNT_W-1:0] shift_next;
    logic             at_zero_q;
    logic             load;

    // Single-quadrant: negative commands become zero, large ones saturate at 180 degrees.
    always_comb begin
        if (phase_cmd[PH_W-1])
            shift_next = '0;
        else if (phase_cmd > HALF_S)
            shift_next = HALF_C;
        else
            shift_next = CNT_W'(phase_cmd);
    end

    assign load = !live || (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            shift     <= '0;
            dead      <= '0;
            at_zero_q <= 1'b0;
            strobe    <= 1'b0;
        end else begin
            if (!live)
                cnt <= '0;
            else if (cnt == LAST)
                cnt <= '0;
            else
                cnt <= cnt + CNT_W'(1);

            if (load) begin
                shift <= shift_next;
                dead  <= dead_cmd;
            end

            // Two stages so the strobe lines up with the registered gates.
            at_zero_q <= live && (cnt == '0);
            strobe    <= live && at_zero_q;
        end
    end

endmodule

// File: rtl/pfb_shaper.sv
module pfb_shaper
    import pfb_pkg::*;
#(
    parameter int PERIOD = 1538,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] shift,
    output gate_vec_t        want
);

    localparam int               HALF   = PERIOD / 2;
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);
    localparam logic [CNT_W:0]   HALF_X = (CNT_W+1)'(HALF);
    localparam logic [CNT_W:0]   PER_X  = (CNT_W+1)'(PERIOD);

    logic [CNT_W:0] lag_pos;
    bridge_pol_t    pol;

    // Position of the lagging leg inside its own delayed carrier.
    always_comb begin
        if (cnt >= shift)
            lag_pos = {1'b0, cnt} - {1'b0, shift};
        else
            lag_pos = {1'b0, cnt} + PER_X - {1'b0, shift};
        pol.lead = (cnt < HALF_C);
        pol.lag  = (lag_pos < HALF_X);
        want     = gate_wants(pol);
    end

endmodule

// File: rtl/pshift_bridge_gen.sv
module pshift_bridge_gen
    import pfb_pkg::*;
#(
    parameter int PERIOD = 1538,
    parameter int PH_W   = 12,
    parameter int DT_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   fault,
    input  logic signed [PH_W-1:0] phase_cmd,
    input  logic [DT_W-1:0]        dead_cmd,
    output logic                   lead_hi,
    output logic                   lead_lo,
    output logic                   lag_hi,
    output logic                   lag_lo,
    output logic                   rect_bc,
    output logic                   rect_ad,
    output logic                   cycle_start
);

    localparam int CNT_W = $clog2(PERIOD);

    logic             live;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shift;
    logic [DT_W-1:0]  dead;
    gate_vec_t        want_vec;
    gate_vec_t        on_vec;
    gate_vec_t        gate_q;

    assign live = en && !fault;

    pfb_carrier #(
        .PERIOD (PERIOD),
        .PH_W   (PH_W),
        .DT_W   (DT_W),
        .CNT_W  (CNT_W)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .live      (live),
        .phase_cmd (phase_cmd),
        .dead_cmd  (dead_cmd),
        .cnt       (cnt),
        .shift     (shift),
        .dead      (dead),
        .strobe    (cycle_start)
    );

    pfb_shaper #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_shaper (
        .cnt   (cnt),
        .shift (shift),
        .want  (want_vec)
    );

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        pfb_gate_timer #(
            .DT_W (DT_W)
        ) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .live (live),
            .want (want_vec[g]),
            .dead (dead),
            .on   (on_vec[g])
        );
    end

    // Output stage: the shutdown request clears every gate at the next edge.
    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= '0;
        else
            gate_q <= live ? on_vec : '0;
    end

    assign lead_hi = gate_q[GI_LEAD_HI];
    assign lead_lo = gate_q[GI_LEAD_LO];
    assign lag_hi  = gate_q[GI_LAG_HI];
    assign lag_lo  = gate_q[GI_LAG_LO];
    assign rect_bc = gate_q[GI_RECT_BC];
    assign rect_ad = gate_q[GI_RECT_AD];

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
    parameter int PERIOD = 1538
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic fault,
    input logic lead_hi,
    input logic lead_lo,
    input logic lag_hi,
    input logic lag_lo,
    input logic rect_bc,
    input logic rect_ad,
    input logic cycle_start
);

    localparam int          GW      = $clog2(PERIOD) + 1;
    localparam logic [GW-1:0] GAP_EXP = GW'(PERIOD - 1);

    logic [GW-1:0] gap;
    logic          seen;
    logic          live;

    assign live = en && !fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else begin
            if (cycle_start)
                gap <= '0;
            else if (gap != '1)
                gap <= gap + GW'(1);
            if (!live)
                seen <= 1'b0;
            else if (cycle_start)
                seen <= 1'b1;
        end
    end

    a_r3_lead_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lead_hi && lead_lo));

    a_r4_lag_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lag_hi && lag_lo));

    a_r1_force_off: assert property (@(posedge clk) disable iff (rst)
        !live |=> !(lead_hi || lead_lo || lag_hi || lag_lo || rect_bc || rect_ad || cycle_start));

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && seen) |-> (gap == GAP_EXP));

    a_r9_rect_bc_blocked: assert property (@(posedge clk) disable iff (rst)
        (lead_hi && lag_lo) |-> !rect_bc);

    a_r9_rect_ad_blocked: assert property (@(posedge clk) disable iff (rst)
        (lead_lo && lag_hi) |-> !rect_ad);

endmodule

bind pshift_bridge_gen pfb_checker #(.PERIOD(PERIOD)) u_pfb_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .fault       (fault),
    .lead_hi     (lead_hi),
    .lead_lo     (lead_lo),
    .lag_hi      (lag_hi),
    .lag_lo      (lag_lo),
    .rect_bc     (rect_bc),
    .rect_ad     (rect_ad),
    .cycle_start (cycle_start)
);

// File: tb/pshift_bridge_gen_test.sv
`timescale 1ns/1ps
module pshift_bridge_gen_test;

    localparam int P = 1538;
    localparam int H = P / 2;

    logic               clk = 1'b0;
    logic               rst;
    logic               en;
    logic               fault;
    logic signed [11:0] phase_cmd;
    logic [5:0]         dead_cmd;
    logic lead_hi, lead_lo, lag_hi, lag_lo, rect_bc, rect_ad, cycle_start;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pshift_bridge_gen uut (
        .clk(clk), .rst(rst), .en(en), .fault(fault),
        .phase_cmd(phase_cmd), .dead_cmd(dead_cmd),
        .lead_hi(lead_hi), .lead_lo(lead_lo), .lag_hi(lag_hi), .lag_lo(lag_lo),
        .rect_bc(rect_bc), .rect_ad(rect_ad), .cycle_start(cycle_start)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] gvec();
        return {rect_ad, rect_bc, lag_lo, lag_hi, lead_lo, lead_hi};
    endfunction

    function automatic bit arc_on(input int t, input int s, input int e);
        if (s == e) return 1'b1;
        if (s < e)  return (t >= s) && (t < e);
        return (t >= s) || (t < e);
    endfunction

    // Expected gate level at offset t after a strobe in steady state.
    function automatic bit exp_gate(input int g, input int t, input int p, input int d);
        case (g)
            0: return arc_on(t, d, H);
            1: return arc_on(t, (H + d) % P, 0);
            2: return arc_on(t, (p + d) % P, (p + H) % P);
            3: return arc_on(t, (p + H + d) % P, p);
            4: return (p == 0) ? 1'b1 : arc_on(t, (p + d) % P, 0);
            default: return (p == 0) ? 1'b1 : arc_on(t, (H + p + d) % P, H);
        endcase
    endfunction

    function automatic string req_of(input int g);
        if (g < 2) return "R3";
        if (g < 4) return "R4";
        return "R7";
    endfunction

    task automatic wait_strobe();
        do @(negedge clk); while (cycle_start !== 1'b1);
    endtask

    task automatic edges_to_strobe(input string req, input string what, input int exp);
        int n = 0;
        do begin @(negedge clk); n++; end while (cycle_start !== 1'b1 && n < 2 * P);
        chk(n == exp, req, what, n, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; fault = 1'b0; phase_cmd = 12'sd300; dead_cmd = 6'd8;
        repeat (4) @(negedge clk);
        chk(gvec() == 6'b0 && cycle_start == 1'b0, "R1", "outputs during reset", int'(gvec()), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(gvec() == 6'b0 && cycle_start == 1'b0, "R1", "outputs while disabled", int'(gvec()), 0);
    endtask

    task automatic t_startup();
        en = 1'b1;
        edges_to_strobe("R2", "edges from enable to first strobe", 2);
        edges_to_strobe("R2", "clocks between strobes", P);
    endtask

    // Apply a command after a strobe, let it settle one period, then check a whole period.
    task automatic t_period(input int pc, input int dc, input int pe, input int de, input string tag);
        int bad_t [6];
        int bad_v [6];
        int strobe_bad = -1;
        int r9_bad = -1;
        logic [5:0] gv;
        for (int g = 0; g < 6; g++) begin bad_t[g] = -1; bad_v[g] = 0; end
        wait_strobe();
        phase_cmd = 12'(pc);
        dead_cmd  = 6'(dc);
        wait_strobe();
        wait_strobe();
        for (int t = 0; t < P; t++) begin
            if (t > 0) @(negedge clk);
            gv = gvec();
            for (int g = 0; g < 6; g++) begin
                if (gv[g] !== exp_gate(g, t, pe, de) && bad_t[g] < 0) begin
                    bad_t[g] = t;
                    bad_v[g] = int'(gv[g]);
                end
            end
            if ((cycle_start !== (t == 0)) && strobe_bad < 0) strobe_bad = t;
            if (((gv[0] && gv[3] && gv[4]) || (gv[1] && gv[2] && gv[5])) && r9_bad < 0) r9_bad = t;
        end
        for (int g = 0; g < 6; g++)
            chk(bad_t[g] < 0, req_of(g),
                $sformatf("[%s p=%0d d=%0d] gate %0d level at offset %0d", tag, pe, de, g, bad_t[g]),
                bad_v[g], 1 - bad_v[g]);
        chk(strobe_bad < 0, "R2", $sformatf("[%s] strobe only at offset 0, offset", tag), strobe_bad, -1);
        chk(r9_bad < 0, "R9", $sformatf("[%s] rectifier on against transfer, offset", tag), r9_bad, -1);
    endtask

    // Requires steady p=300, d=6 on entry.
    task automatic t_latch();
        int fall_d = -1;
        int rise_b = -1;
        int rise_a = -1;
        logic pd, pb, pa;
        wait_strobe();
        pd = lag_lo; pb = lead_lo;
        for (int t = 1; t < P; t++) begin
            @(negedge clk);
            if (t == 100) begin phase_cmd = 12'sd500; dead_cmd = 6'd20; end
            if (pd && !lag_lo && fall_d < 0) fall_d = t;
            if (!pb && lead_lo && rise_b < 0) rise_b = t;
            pd = lag_lo; pb = lead_lo;
        end
        chk(fall_d == 300, "R6", "old shift kept: lag_lo fall offset", fall_d, 300);
        chk(rise_b == H + 6, "R6", "old dead time kept: lead_lo rise offset", rise_b, H + 6);
        @(negedge clk);
        chk(cycle_start == 1'b1, "R2", "strobe after a full period", int'(cycle_start), 1);
        fall_d = -1;
        pd = lag_lo; pa = lead_hi;
        for (int t = 1; t < P; t++) begin
            @(negedge clk);
            if (pd && !lag_lo && fall_d < 0) fall_d = t;
            if (!pa && lead_hi && rise_a < 0) rise_a = t;
            pd = lag_lo; pa = lead_hi;
        end
        chk(fall_d == 500, "R6", "new shift applied: lag_lo fall offset", fall_d, 500);
        chk(rise_a == 20, "R6", "new dead time applied: lead_hi rise offset", rise_a, 20);
    endtask

    task automatic t_fault();
        wait_strobe();
        repeat (200) @(negedge clk);
        chk(lead_hi == 1'b1, "R3", "lead_hi mid half-cycle", int'(lead_hi), 1);
        fault = 1'b1;
        @(negedge clk);
        chk(gvec() == 6'b0 && !cycle_start, "R1", "gates one edge after fault", int'(gvec()), 0);
        repeat (30) @(negedge clk);
        chk(gvec() == 6'b0 && !cycle_start, "R1", "gates while fault held", int'(gvec()), 0);
        fault = 1'b0;
        edges_to_strobe("R2", "edges from fault release to strobe", 2);
    endtask

    task automatic t_disable();
        wait_strobe();
        repeat (H + 100) @(negedge clk);
        chk(lead_lo == 1'b1, "R3", "lead_lo in second half", int'(lead_lo), 1);
        en = 1'b0;
        @(negedge clk);
        chk(gvec() == 6'b0 && !cycle_start, "R1", "gates one edge after disable", int'(gvec()), 0);
        repeat (P + 10) @(negedge clk);
        chk(gvec() == 6'b0 && !cycle_start, "R1", "no strobe or gate while disabled", int'(gvec()), 0);
        en = 1'b1;
        edges_to_strobe("R2", "edges from re-enable to strobe", 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual %0d cycles expected fewer", 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_period(300, 8, 300, 8, "R3");
        t_period(0, 8, 0, 8, "R7");
        t_period(-50, 5, 0, 5, "R5");
        t_period(2000, 4, H, 4, "R5");
        t_period(400, 0, 400, 0, "R8");
        t_period(300, 6, 300, 6, "R4");
        t_latch();
        t_fault();
        t_disable();
        t_period(600, 12, 600, 12, "R9");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule